// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic stage of a small eight-bit processor core. Each cycle it may accept one operation with a destination operand, a source operand and an immediate constant. One clock edge later it presents the eight-bit result, a write-back enable and, for the two multiplies, a sixteen-bit product. On that same edge it updates a six-bit status register that holds carry, zero, negative, signed overflow, half-carry and interrupt-enable.

The surrounding core holds the register file, decodes opcodes and performs memory access. It feeds this block an already decoded operation code. It writes back `result` only when `wb_en` is high. Compare and test only update the flags, so that a later conditional branch can act on them. The interrupt-enable bit has its own write port, so the core can set or clear it in any cycle, with or without an operation.

Top module: `alu8_flags`

## Requirements
- R1: The status flags sit at fixed bit positions: `flags[0]` carry, `flags[1]` zero, `flags[2]` negative, `flags[3]` signed overflow, `flags[4]` half-carry, `flags[5]` interrupt-enable. Add (`op_sel` 0) returns dst+src and writes back. It sets carry on a carry out of bit 7 and half-carry on a carry from bit 3 into bit 4. It sets overflow when the signed sum lies outside -128..127, zero when the 8-bit result is 0, and negative from result bit 7.
- R2: Add-with-carry (`op_sel` 1) returns dst+src+carry, using the carry flag as it stood before the operation. Its flags follow the R1 rules.
- R3: Compare (`op_sel` 7) computes dst-src and does not write back (`wb_en`=0). Carry is set when dst<src, treated as unsigned. Half-carry is set when dst[3:0]<src[3:0]. Overflow marks signed overflow of the difference. Zero and negative come from the difference.
- R4: Test (`op_sel` 8) does not write back. It sets zero and negative from dst, clears overflow, and leaves carry and half-carry unchanged.
- R5: Negate (`op_sel` 2) returns 0-dst and writes back. Carry is set when dst≠0, half-carry when dst[3:0]≠0, and overflow only when dst=0x80.
- R6: AND (`op_sel` 3) and XOR (`op_sel` 5) combine dst with src. AND-immediate (`op_sel` 4) combines dst with `imm_val` and ignores src. All three write back, clear overflow, set zero and negative from the result, and leave carry and half-carry unchanged.
- R7: Increment (`op_sel` 6) returns dst+1 and writes back. Overflow is set only for dst=0x7F. Zero and negative come from the result. Carry and half-carry are unchanged.
- R8: Unsigned multiply (`op_sel` 9) and signed multiply (`op_sel` 10) place the 16-bit product on `product` and its low byte on `result`, and write back. Carry is set from product bit 15 and zero when the whole product is 0. Negative, overflow and half-carry are unchanged. `product` is 0 after every other operation.
- R9: When `ie_wr` is 1, `flags[5]` takes `ie_data` at the next edge, whether or not an operation is issued in the same cycle. No operation ever changes `flags[5]`.
- R10: While `rst_n` is low at a clock edge, all flags, `result`, `product`, `wb_en` and `res_valid` clear to 0.
- R11: An accepted operation (`op_valid`=1 with `op_sel` 0 to 10) shows its outputs and updated flags one cycle later, with `res_valid`=1 for exactly that cycle. With `op_valid`=0, or with `op_sel` 11 to 15, no result is produced (`res_valid`=0, `wb_en`=0) and flags 0 to 4 keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation issued this cycle |
| op_sel | input | 4 | Decoded operation code |
| dst_opnd | input | 8 | Destination operand |
| src_opnd | input | 8 | Source operand |
| imm_val | input | 8 | Immediate constant for AND-immediate |
| ie_wr | input | 1 | Write strobe for the interrupt-enable bit |
| ie_data | input | 1 | Value written to interrupt-enable |
| res_valid | output | 1 | Outputs belong to an operation accepted last cycle |
| result | output | 8 | Eight-bit result |
| wb_en | output | 1 | Result should be written to the destination |
| product | output | 16 | Sixteen-bit multiply product |
| flags | output | 6 | Status register {IE, H, V, N, Z, C} |

## Verification
The bench targets the edges where flag logic usually breaks. These include 0x7F+1 and 0x80+0x80 for overflow, 0x0F+1 for half-carry, and negate of 0x80 and 0x00. They also include compare with dst<src, where a design that forgets to invert the adder's carry reports no borrow. Other cases check that increment, the logical ops and test leave carry untouched. A design that reused the adder's carry there would flip it. Another checks that add-with-carry reads the carry produced by the previous operation rather than the new one. Signed multiply of 0xFF by 0xFF must give 1 and not 0xFE01. An interrupt-enable write that comes with an operation must survive, and an unused code must leave the flags alone.

// File: rtl/alu8_pkg.sv
// Shared definitions for the eight-bit ALU: operation codes, flag bit
// positions and data widths. Assumes the decoder upstream emits these codes.
package alu8_pkg;
    localparam int DW = 8;
    localparam int PW = 2 * DW;
    localparam int FW = 6;

    localparam int F_C  = 0;
    localparam int F_Z  = 1;
    localparam int F_N  = 2;
    localparam int F_V  = 3;
    localparam int F_H  = 4;
    localparam int F_IE = 5;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_NEG  = 4'd2,
        OP_AND  = 4'd3,
        OP_ANDI = 4'd4,
        OP_XOR  = 4'd5,
        OP_INC  = 4'd6,
        OP_CMP  = 4'd7,
        OP_TST  = 4'd8,
        OP_MULU = 4'd9,
        OP_MULS = 4'd10
    } alu_op_e;

    localparam logic [3:0] OP_LAST = 4'd10;
endpackage

// File: rtl/alu8_addsub.sv
// Shared adder/subtractor. With sub=1 it computes a-b-cin using the
// inverted operand, and reports carry as a borrow. Assumes W >= 5.
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         h_out,
    output logic         v_out
);
    localparam int NIB = 4;

    logic [W-1:0] b_eff;
    logic         c_in_eff;
    logic [W:0]   full;
    logic [NIB:0] low;

    // Form the effective operand and the carry-in for add or subtract.
    always_comb begin
        b_eff    = sub ? ~b : b;
        c_in_eff = sub ? ~cin : cin;
        full     = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_in_eff};
        low      = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_in_eff};
        sum      = full[W-1:0];
        c_out    = full[W] ^ sub;
        h_out    = low[NIB] ^ sub;
        v_out    = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
// Bitwise unit: AND when use_xor=0, XOR when use_xor=1. Purely combinational.
module alu8_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         use_xor,
    output logic [W-1:0] y
);
    // Select the bitwise function.
    always_comb y = use_xor ? (a ^ b) : (a & b);
endmodule

// File: rtl/alu8_mul.sv
// W x W multiplier with a 2W-bit product. SIGNED picks two's-complement
// operands; otherwise the operands are unsigned.
module alu8_mul #(
    parameter int W      = 8,
    parameter bit SIGNED = 1'b0
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int PW = 2 * W;

    generate
        if (SIGNED) begin : g_signed
            logic signed [PW-1:0] sa, sb, sp;
            // Sign-extend and multiply.
            always_comb begin
                sa = {{W{a[W-1]}}, a};
                sb = {{W{b[W-1]}}, b};
                sp = sa * sb;
                p  = sp;
            end
        end else begin : g_unsigned
            logic [PW-1:0] ua, ub;
            // Zero-extend and multiply.
            always_comb begin
                ua = {{W{1'b0}}, a};
                ub = {{W{1'b0}}, b};
                p  = ua * ub;
            end
        end
    endgenerate
endmodule

// File: rtl/alu8_flags.sv
// Top of the ALU: decodes the operation code, steers the shared adder,
// logic unit and two multipliers, and holds the six-bit status register.
// Outputs are registered: one cycle of latency. Assumes the core applies
// an operation only when the previous flags should be used.
module alu8_flags
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_sel,
    input  logic [DW-1:0] dst_opnd,
    input  logic [DW-1:0] src_opnd,
    input  logic [DW-1:0] imm_val,
    input  logic          ie_wr,
    input  logic          ie_data,
    output logic          res_valid,
    output logic [DW-1:0] result,
    output logic          wb_en,
    output logic [PW-1:0] product,
    output logic [FW-1:0] flags
);
    logic [DW-1:0] as_a, as_b, as_sum;
    logic          as_cin, as_sub, as_c, as_h, as_v;
    logic [DW-1:0] lg_b, lg_y;
    logic          lg_xor;
    logic [PW-1:0] mul_p [2];

    logic          accept;
    logic [DW-1:0] nxt_res;
    logic [PW-1:0] nxt_prod;
    logic          nxt_wb, nxt_mul;
    logic [FW-1:0] nxt_flags;

    logic [FW-1:0] flags_q;
    logic [DW-1:0] result_q;
    logic [PW-1:0] product_q;
    logic          wb_q, valid_q, last_mul_q;

    alu8_addsub #(.W(DW)) u_addsub (
        .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .c_out(as_c), .h_out(as_h), .v_out(as_v)
    );

    alu8_logic #(.W(DW)) u_logic (
        .a(dst_opnd), .b(lg_b), .use_xor(lg_xor), .y(lg_y)
    );

    genvar gi;
    generate
        for (gi = 0; gi < 2; gi++) begin : g_mul
            alu8_mul #(.W(DW), .SIGNED(gi == 1)) u_mul (
                .a(dst_opnd), .b(src_opnd), .p(mul_p[gi])
            );
        end
    endgenerate

    // Operation decode: steer operands and build next result and flags.
    always_comb begin
        accept    = op_valid && (op_sel <= OP_LAST);
        as_a      = dst_opnd;
        as_b      = src_opnd;
        as_cin    = 1'b0;
        as_sub    = 1'b0;
        lg_b      = src_opnd;
        lg_xor    = 1'b0;
        nxt_res   = '0;
        nxt_prod  = '0;
        nxt_wb    = 1'b0;
        nxt_mul   = 1'b0;
        nxt_flags = flags_q;
        if (accept) begin
            case (alu_op_e'(op_sel))
                OP_ADD, OP_ADC, OP_CMP, OP_NEG: begin
                    as_cin = (op_sel == OP_ADC) ? flags_q[F_C] : 1'b0;
                    as_sub = (op_sel == OP_CMP) || (op_sel == OP_NEG);
                    if (op_sel == OP_NEG) begin
                        as_a = '0;
                        as_b = dst_opnd;
                    end
                    nxt_res        = as_sum;
                    nxt_wb         = (op_sel != OP_CMP);
                    nxt_flags[F_C] = as_c;
                    nxt_flags[F_H] = as_h;
                    nxt_flags[F_V] = as_v;
                end
                OP_INC: begin
                    as_b           = DW'(1);
                    nxt_res        = as_sum;
                    nxt_wb         = 1'b1;
                    nxt_flags[F_V] = as_v;
                end
                OP_AND, OP_ANDI, OP_XOR, OP_TST: begin
                    lg_b           = (op_sel == OP_ANDI) ? imm_val :
                                     (op_sel == OP_TST)  ? dst_opnd : src_opnd;
                    lg_xor         = (op_sel == OP_XOR);
                    nxt_res        = lg_y;
                    nxt_wb         = (op_sel != OP_TST);
                    nxt_flags[F_V] = 1'b0;
                end
                default: begin
                    nxt_mul        = 1'b1;
                    nxt_prod       = (op_sel == OP_MULS) ? mul_p[1] : mul_p[0];
                    nxt_res        = nxt_prod[DW-1:0];
                    nxt_wb         = 1'b1;
                    nxt_flags[F_C] = nxt_prod[PW-1];
                end
            endcase
            if (!nxt_mul) begin
                nxt_flags[F_Z] = (nxt_res == '0);
                nxt_flags[F_N] = nxt_res[DW-1];
            end else begin
                nxt_flags[F_Z] = (nxt_prod == '0);
            end
        end
        nxt_flags[F_IE] = ie_wr ? ie_data : flags_q[F_IE];
    end

    // Status register and registered outputs, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q    <= '0;
            result_q   <= '0;
            product_q  <= '0;
            wb_q       <= 1'b0;
            valid_q    <= 1'b0;
            last_mul_q <= 1'b0;
        end else begin
            flags_q    <= nxt_flags;
            valid_q    <= accept;
            wb_q       <= nxt_wb;
            last_mul_q <= nxt_mul;
            if (accept) begin
                result_q  <= nxt_res;
                product_q <= nxt_prod;
            end
        end
    end

    assign flags     = flags_q;
    assign result    = result_q;
    assign product   = product_q;
    assign wb_en     = wb_q;
    assign res_valid = valid_q;

    // Compare and test never request a write-back.
    assert_cmp_tst_no_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == OP_CMP || op_sel == OP_TST)) |=> (res_valid && !wb_en));

    // Test and logical ops clear overflow; test keeps carry (R4, R6).
    assert_logic_clears_v_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == OP_AND || op_sel == OP_ANDI || op_sel == OP_XOR || op_sel == OP_TST))
        |=> (!flags[F_V] && flags[F_C] == $past(flags[F_C])));

    // Increment leaves carry as it was.
    assert_inc_keeps_c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_INC) |=> (flags[F_C] == $past(flags[F_C])));

    // Zero and negative track the 8-bit result of non-multiply operations.
    assert_zn_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !last_mul_q) |-> (flags[F_Z] == (result == '0) && flags[F_N] == result[DW-1]));

    // Multiply carry comes from product bit 15.
    assert_mul_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && last_mul_q) |-> (flags[F_C] == product[PW-1] && flags[F_Z] == (product == '0)));

    // Interrupt-enable follows its write port.
    assert_ie_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ie_wr |=> (flags[F_IE] == $past(ie_data)));

    // Operations never touch interrupt-enable.
    assert_ie_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_wr |=> $stable(flags[F_IE]));

    // No accepted operation: no result and arithmetic flags hold.
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_sel <= OP_LAST) |=> (!res_valid && !wb_en && $stable(flags[F_H:F_C])));
endmodule

// File: tb/sim_alu8_flags.sv
// Scoreboard bench: the driver computes expected outputs from the
// requirements and queues them; the monitor compares after each edge.
module sim_alu8_flags;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [7:0]  res;
        logic        wb;
        logic [15:0] prod;
        logic [5:0]  flg;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [7:0]  dst_opnd = '0, src_opnd = '0, imm_val = '0;
    logic        ie_wr = 1'b0, ie_data = 1'b0;
    logic        res_valid, wb_en;
    logic [7:0]  result;
    logic [15:0] product;
    logic [5:0]  flags;

    int          vectors = 0;
    int          miscompares = 0;
    logic [5:0]  model_f = '0;
    exp_t        sb_q[$];
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_flags u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .dst_opnd(dst_opnd), .src_opnd(src_opnd), .imm_val(imm_val),
        .ie_wr(ie_wr), .ie_data(ie_data), .res_valid(res_valid),
        .result(result), .wb_en(wb_en), .product(product), .flags(flags)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [3:0] op, input logic [7:0] d,
                                   input logic [7:0] s, input logic [7:0] im,
                                   input logic [5:0] f);
        exp_t e;
        int u, sv, sd, ss, ci;
        logic [7:0] r;
        e.flg = f; e.prod = '0; e.wb = 1'b1; r = '0;
        sd = $signed(d); ss = $signed(s);
        case (op)
            4'd0, 4'd1: begin
                ci = (op == 4'd1) ? int'(f[0]) : 0;
                u = int'(d) + int'(s) + ci; sv = sd + ss + ci; r = u[7:0];
                e.flg[0] = u > 255;
                e.flg[4] = (int'(d & 8'hF) + int'(s & 8'hF) + ci) > 15;
                e.flg[3] = (sv > 127) || (sv < -128);
                e.req = (op == 4'd0) ? "R1" : "R2";
            end
            4'd7: begin
                u = int'(d) - int'(s); sv = sd - ss; r = u[7:0];
                e.flg[0] = d < s; e.flg[4] = (d & 8'hF) < (s & 8'hF);
                e.flg[3] = (sv > 127) || (sv < -128); e.wb = 1'b0; e.req = "R3";
            end
            4'd8: begin r = d; e.flg[3] = 1'b0; e.wb = 1'b0; e.req = "R4"; end
            4'd2: begin
                u = 0 - int'(d); r = u[7:0];
                e.flg[0] = d != 0; e.flg[4] = (d & 8'hF) != 0;
                e.flg[3] = d == 8'h80; e.req = "R5";
            end
            4'd3, 4'd4, 4'd5: begin
                r = (op == 4'd3) ? (d & s) : (op == 4'd4) ? (d & im) : (d ^ s);
                e.flg[3] = 1'b0; e.req = "R6";
            end
            4'd6: begin u = int'(d) + 1; r = u[7:0]; e.flg[3] = d == 8'h7F; e.req = "R7"; end
            default: begin
                if (op == 4'd9) u = int'(d) * int'(s); else u = sd * ss;
                e.prod = u[15:0]; r = u[7:0];
                e.flg[0] = e.prod[15]; e.flg[1] = e.prod == 0; e.req = "R8";
            end
        endcase
        if (op < 4'd9) begin e.flg[1] = (r == 0); e.flg[2] = r[7]; end
        e.res = r;
        return e;
    endfunction

    // Driver: apply one operation at the falling edge and queue its expectation.
    task automatic drive(input logic [3:0] op, input logic [7:0] d, input logic [7:0] s,
                         input logic [7:0] im, input logic iew, input logic ied);
        exp_t e;
        @(negedge clk);
        op_valid = 1'b1; op_sel = op; dst_opnd = d; src_opnd = s; imm_val = im;
        ie_wr = iew; ie_data = ied;
        if (op <= 4'd10) begin
            e = model(op, d, s, im, model_f);
            if (iew) e.flg[5] = ied;
            sb_q.push_back(e);
            model_f = e.flg;
        end else if (iew) begin
            model_f[5] = ied;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid = 1'b0; ie_wr = 1'b0;
    endtask

    // Monitor: compare a quarter period after each rising edge.
    always @(posedge clk) begin
        exp_t e;
        #(CLK_PERIOD/4);
        if (rst_n && res_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R11", "unexpected res_valid", 32'd1, 32'd0);
            end else begin
                e = sb_q.pop_front();
                check(result == e.res && wb_en == e.wb && product == e.prod && flags == e.flg,
                      e.req, "res/wb/prod/flags",
                      {result, 1'b0, wb_en, flags, product[15:8]},
                      {e.res, 1'b0, e.wb, e.flg, e.prod[15:8]});
                check(product[7:0] == e.prod[7:0], e.req, "product low",
                      {24'd0, product[7:0]}, {24'd0, e.prod[7:0]});
            end
        end
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [5:0] hold;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        // R10: reset state
        check(flags == 6'd0 && result == 8'd0 && product == 16'd0 && !wb_en && !res_valid,
              "R10", "reset state", {10'd0, flags, result, 7'd0, wb_en}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1 add corners
        drive(4'd0, 8'h0F, 8'h01, 8'h00, 0, 0);
        drive(4'd0, 8'h80, 8'h80, 8'h00, 0, 0);
        drive(4'd0, 8'h7F, 8'h01, 8'h00, 0, 0);
        // R2 add-with-carry after carry set and after carry clear
        drive(4'd0, 8'hFF, 8'h01, 8'h00, 0, 0);
        drive(4'd1, 8'hFF, 8'h00, 8'h00, 0, 0);
        drive(4'd1, 8'h10, 8'h20, 8'h00, 0, 0);
        // R3 compare
        drive(4'd7, 8'h10, 8'h20, 8'h00, 0, 0);
        drive(4'd7, 8'h55, 8'h55, 8'h00, 0, 0);
        drive(4'd7, 8'h80, 8'h01, 8'h00, 0, 0);
        // R4 test keeps carry
        drive(4'd7, 8'h00, 8'h01, 8'h00, 0, 0);
        drive(4'd8, 8'h00, 8'hAA, 8'h00, 0, 0);
        drive(4'd8, 8'h80, 8'h00, 8'h00, 0, 0);
        // R5 negate
        drive(4'd2, 8'h80, 8'h00, 8'h00, 0, 0);
        drive(4'd2, 8'h00, 8'h00, 8'h00, 0, 0);
        drive(4'd2, 8'h01, 8'h00, 8'h00, 0, 0);
        // R6 logic; ANDI ignores src
        drive(4'd0, 8'h80, 8'h80, 8'h00, 0, 0);
        drive(4'd3, 8'hF0, 8'h3C, 8'h00, 0, 0);
        drive(4'd4, 8'hF0, 8'hFF, 8'h0F, 0, 0);
        drive(4'd5, 8'hA5, 8'hA5, 8'h00, 0, 0);
        // R7 increment
        drive(4'd7, 8'h00, 8'h01, 8'h00, 0, 0);
        drive(4'd6, 8'h7F, 8'h00, 8'h00, 0, 0);
        drive(4'd6, 8'hFF, 8'h00, 8'h00, 0, 0);
        // R8 multiply
        drive(4'd9, 8'hFF, 8'hFF, 8'h00, 0, 0);
        drive(4'd10, 8'hFF, 8'hFF, 8'h00, 0, 0);
        drive(4'd10, 8'h80, 8'h7F, 8'h00, 0, 0);
        drive(4'd9, 8'h00, 8'h37, 8'h00, 0, 0);
        drive(4'd0, 8'h01, 8'h01, 8'h00, 0, 0);
        // R9 interrupt-enable written alongside an operation, then held
        drive(4'd0, 8'h02, 8'h03, 8'h00, 1, 1);
        drive(4'd5, 8'hFF, 8'h0F, 8'h00, 0, 0);
        drive(4'd2, 8'h05, 8'h00, 8'h00, 1, 0);
        idle();

        // R11 unused code with op_valid: no result, arithmetic flags hold
        drive(4'd0, 8'h80, 8'h80, 8'h00, 0, 0);
        drive(4'd12, 8'h01, 8'h01, 8'h00, 1, 1);
        @(posedge clk); #(CLK_PERIOD/4);
        hold = model_f;
        @(posedge clk); #(CLK_PERIOD/4);
        check(!res_valid && !wb_en, "R11", "unused code res_valid/wb_en",
              {30'd0, res_valid, wb_en}, 32'd0);
        check(flags == hold, "R11", "unused code flags", {26'd0, flags}, {26'd0, hold});
        check(flags[5] == 1'b1, "R9", "IE write without op", {31'd0, flags[5]}, 32'd1);
        idle();
        @(posedge clk); #(CLK_PERIOD/4);
        check(!res_valid && flags == hold, "R11", "idle holds flags",
              {25'd0, res_valid, flags}, {26'd0, hold});

        // Mixed random stream across all requirements
        for (int i = 0; i < 300; i++) begin
            drive(4'($urandom_range(0, 10)), 8'($urandom), 8'($urandom), 8'($urandom),
                  1'($urandom_range(0, 3) == 0), 1'($urandom));
        end
        idle();
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        check(sb_q.size() == 0, "R11", "scoreboard drained", sb_q.size(), 32'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule